// File: doc/BRIEF.md
# Randomly Scheduled Cellular Signal Grid

This block holds a rectangular array of identical cells. The state does not sit inside the cells. It sits in 2-bit edge memories, one on every side of every cell, and each inner edge memory is shared by the two cells that touch it. On each clock cycle a 16-bit linear feedback shift register picks exactly one cell. If the four memories around that cell match one of the built-in transition rules, the cell rewrites all four memories at once. If none match, nothing changes. Because only one cell acts per cycle, two neighbours never act together, so a shared memory is never written twice in one cycle.

There are two rule families, and each is applied in all four orientations. The propagation rule moves a travelling signal one cell onward. The split rule fires when a signal arrives opposite a marker memory holding 11. It removes the incoming signal, sends one new signal out of each of the two side memories, and leaves the marker in place. Markers are placed by parameter at reset. Signals enter through an injection port that addresses any boundary edge memory. A signal that leaves the array through a boundary edge produces a one-cycle pulse on that edge's output bit, and that boundary memory stays empty. Every edge memory can be observed through two flat output buses.

Top module: `aca_grid`

## Requirements
- R1: After a synchronous active-low reset, every edge memory reads 00, except the memories named in the marker parameters, which read 11. All emit outputs are low.
- R2: Each cycle the scheduler, a nonzero 16-bit LFSR, selects one cell index below ROWS*COLS. At most one cell performs a transition in any cycle.
- R3: The propagation rule applies to a selected cell that has one memory holding an incoming signal and three memories holding 00. The cell clears the incoming memory and writes an outgoing signal into the opposite memory. A signal injected on any of the four boundary sides crosses the empty array in a straight line.
- R4: The split rule applies to a selected cell that has an incoming signal, 11 in the opposite memory, and 00 in both side memories. The cell clears the input and writes an outgoing signal into both side memories. The marker keeps the value 11 forever.
- R5: A selected cell whose memories match no rule leaves all four memories unchanged. For example, a signal that reaches a marker cell from one of its sides stays where it is.
- R6: Edge memory encoding is 00 empty, 11 marker, 01 a signal moving toward higher row or column index (south or east), and 10 a signal moving toward lower index (north or west). Row 0 is the north edge and column 0 is the west edge. Horizontal memory (r,c) sits at bits 2*(r*COLS+c) of hmem_o. Vertical memory (r,c) sits at bits 2*(r*(COLS+1)+c) of vmem_o.
- R7: An injection pulse with side code 0=north, 1=east, 2=south, 3=west and index idx loads an inward-moving signal into that boundary memory on the next edge, if the memory is 00. An index at or beyond the length of that side is ignored.
- R8: When a transition writes an outgoing signal onto a boundary edge, the matching emit bit pulses high for exactly one cycle and the boundary memory stays 00.
- R9: In a cycle with no transition and no injection, no edge memory changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inj_valid_i | input | 1 | Injection request, one cycle |
| inj_side_i | input | 2 | Boundary side of the injection |
| inj_idx_i | input | IDX_W | Column or row along that side |
| hmem_o | output | 2*(ROWS+1)*COLS | All horizontal edge memories |
| vmem_o | output | 2*ROWS*(COLS+1) | All vertical edge memories |
| emit_n_o | output | COLS | Signal left through the north edge |
| emit_s_o | output | COLS | Signal left through the south edge |
| emit_w_o | output | ROWS | Signal left through the west edge |
| emit_e_o | output | ROWS | Signal left through the east edge |

## Verification
A wrong rule match or a wrong orientation mapping shows up at the emit ports. Either a pulse appears on the wrong boundary bit, or no pulse appears at all. This becomes visible within a few hundred cycles, because the scheduler visits every cell often. A corrupted memory write leaves a stray value on the memory buses that never clears. The bench therefore compares the full edge state once activity has died down. A lost or overwritten marker turns a split into a straight pass, which produces a single pulse on the opposite edge instead of two pulses on the sides.

// File: rtl/aca_pkg.sv
// Shared encodings for the cellular grid.
// Edge memory values: 00 empty, 11 marker, 01 moving to higher index, 10 to lower.
// Cell view of a memory is {inner half, outer half} as seen from that cell.
package aca_pkg;
    typedef logic [1:0] mem_t;

    localparam mem_t MEM_EMPTY = 2'b00;
    localparam mem_t MEM_MARK  = 2'b11;
    localparam mem_t PHYS_INC  = 2'b01;
    localparam mem_t PHYS_DEC  = 2'b10;
    localparam mem_t VIEW_IN   = 2'b10;
    localparam mem_t VIEW_OUT  = 2'b01;

    // Side order around a cell; rotation is +1 modulo 4.
    localparam logic [1:0] SIDE_N = 2'd0;
    localparam logic [1:0] SIDE_E = 2'd1;
    localparam logic [1:0] SIDE_S = 2'd2;
    localparam logic [1:0] SIDE_W = 2'd3;

    // Exchanges the two halves; maps north and west memories between views.
    function automatic mem_t swap_half(input mem_t m);
        return {m[0], m[1]};
    endfunction
endpackage

// File: rtl/aca_scheduler.sv
// Picks one cell per cycle from a 16-bit Fibonacci LFSR.
// Assumes SEED is nonzero; the pick is the LFSR value modulo NCELLS.
module aca_scheduler #(
    parameter int          NCELLS = 16,
    parameter int          SEL_W  = 4,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] pick_o
);
    logic [15:0] lfsr_q;
    logic        fb;

    // Taps 16,14,13,11 give a maximal-length sequence.
    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // Advance the shift register once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[14:0], fb};
    end

    assign pick_o = SEL_W'(lfsr_q % 16'(NCELLS));

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000); // R2
    AST_PICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pick_o) < NCELLS); // R2
endmodule

// File: rtl/aca_cell.sv
// Rule matcher for one cell, combinational.
// Input is the cell view of its four memories, indexed N,E,S,W.
// Outputs write enables and new cell-view values; nothing is written unless selected.
module aca_cell
    import aca_pkg::*;
(
    input  logic            sel_i,
    input  logic [3:0][1:0] mem_i,
    output logic            fire_o,
    output logic [3:0]      wr_o,
    output logic [3:0][1:0] val_o
);
    logic [3:0] sig_m;
    logic [3:0] fork_m;

    // Match both rule families for every incoming side (rotations).
    always_comb begin
        sig_m  = '0;
        fork_m = '0;
        for (int d = 0; d < 4; d++) begin
            sig_m[2'(d)]  = (mem_i[2'(d)] == VIEW_IN)
                         && (mem_i[2'(d + 1)] == MEM_EMPTY)
                         && (mem_i[2'(d + 2)] == MEM_EMPTY)
                         && (mem_i[2'(d + 3)] == MEM_EMPTY);
            fork_m[2'(d)] = (mem_i[2'(d)] == VIEW_IN)
                         && (mem_i[2'(d + 2)] == MEM_MARK)
                         && (mem_i[2'(d + 1)] == MEM_EMPTY)
                         && (mem_i[2'(d + 3)] == MEM_EMPTY);
        end
    end

    assign fire_o = sel_i && (|(sig_m | fork_m));

    // Produce the right-hand side of whichever rule matched.
    always_comb begin
        wr_o  = '0;
        val_o = '0;
        if (sel_i) begin
            for (int d = 0; d < 4; d++) begin
                if (sig_m[2'(d)]) begin
                    wr_o[2'(d)]      = 1'b1;
                    val_o[2'(d)]     = MEM_EMPTY;
                    wr_o[2'(d + 2)]  = 1'b1;
                    val_o[2'(d + 2)] = VIEW_OUT;
                end else if (fork_m[2'(d)]) begin
                    wr_o[2'(d)]      = 1'b1;
                    val_o[2'(d)]     = MEM_EMPTY;
                    wr_o[2'(d + 1)]  = 1'b1;
                    val_o[2'(d + 1)] = VIEW_OUT;
                    wr_o[2'(d + 3)]  = 1'b1;
                    val_o[2'(d + 3)] = VIEW_OUT;
                end
            end
        end
    end
endmodule

// File: rtl/aca_grid.sv
// Array of ROWS x COLS cells sharing 2-bit edge memories, one cell acting per cycle.
// Assumes IDX_W can hold max(ROWS, COLS) and marker parameters name inner edges.
// Outgoing signals written onto a boundary edge become one-cycle emit pulses.
module aca_grid
    import aca_pkg::*;
#(
    parameter int                          ROWS   = 4,
    parameter int                          COLS   = 4,
    parameter int                          IDX_W  = 3,
    parameter logic [15:0]                 SEED   = 16'hACE1,
    parameter logic [(ROWS+1)*COLS-1:0]    MARK_H = '0,
    parameter logic [ROWS*(COLS+1)-1:0]    MARK_V = 20'h00080
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inj_valid_i,
    input  logic [1:0]                    inj_side_i,
    input  logic [IDX_W-1:0]              inj_idx_i,
    output logic [2*(ROWS+1)*COLS-1:0]    hmem_o,
    output logic [2*ROWS*(COLS+1)-1:0]    vmem_o,
    output logic [COLS-1:0]               emit_n_o,
    output logic [COLS-1:0]               emit_s_o,
    output logic [ROWS-1:0]               emit_w_o,
    output logic [ROWS-1:0]               emit_e_o
);
    localparam int NCELLS = ROWS * COLS;
    localparam int SEL_W  = (NCELLS > 1) ? $clog2(NCELLS) : 1;
    localparam int NH     = (ROWS + 1) * COLS;
    localparam int NV     = ROWS * (COLS + 1);

    logic [NH-1:0][1:0]          hmem_q, hmem_d;
    logic [NV-1:0][1:0]          vmem_q, vmem_d;
    logic [COLS-1:0]             en_n_d, en_s_d;
    logic [ROWS-1:0]             en_w_d, en_e_d;
    logic [SEL_W-1:0]            pick;
    logic [NCELLS-1:0]           fire;
    logic [NCELLS-1:0][3:0]      cwr;
    logic [NCELLS-1:0][3:0][1:0] cval;
    logic                        inj_ok;
    logic                        inj_do;

    aca_scheduler #(.NCELLS(NCELLS), .SEL_W(SEL_W), .SEED(SEED)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .pick_o (pick)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K = r * COLS + c;
            logic [3:0][1:0] view;
            assign view[SIDE_N] = swap_half(hmem_q[r * COLS + c]);
            assign view[SIDE_S] = hmem_q[(r + 1) * COLS + c];
            assign view[SIDE_W] = swap_half(vmem_q[r * (COLS + 1) + c]);
            assign view[SIDE_E] = vmem_q[r * (COLS + 1) + c + 1];
            aca_cell u_cell (
                .sel_i  (pick == SEL_W'(K)),
                .mem_i  (view),
                .fire_o (fire[K]),
                .wr_o   (cwr[K]),
                .val_o  (cval[K])
            );
        end
    end

    // Injection is legal when the index lies on the chosen side.
    always_comb begin
        if (inj_side_i == SIDE_N || inj_side_i == SIDE_S) inj_ok = 32'(inj_idx_i) < COLS;
        else                                              inj_ok = 32'(inj_idx_i) < ROWS;
    end

    // Merge the acting cell's writes and any injection into the next state.
    always_comb begin
        hmem_d = hmem_q;
        vmem_d = vmem_q;
        en_n_d = '0;
        en_s_d = '0;
        en_w_d = '0;
        en_e_d = '0;
        inj_do = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (cwr[r * COLS + c][SIDE_N]) begin
                    if (r == 0 && cval[r * COLS + c][SIDE_N] != MEM_EMPTY) en_n_d[c] = 1'b1;
                    else hmem_d[r * COLS + c] = swap_half(cval[r * COLS + c][SIDE_N]);
                end
                if (cwr[r * COLS + c][SIDE_S]) begin
                    if (r == ROWS - 1 && cval[r * COLS + c][SIDE_S] != MEM_EMPTY) en_s_d[c] = 1'b1;
                    else hmem_d[(r + 1) * COLS + c] = cval[r * COLS + c][SIDE_S];
                end
                if (cwr[r * COLS + c][SIDE_W]) begin
                    if (c == 0 && cval[r * COLS + c][SIDE_W] != MEM_EMPTY) en_w_d[r] = 1'b1;
                    else vmem_d[r * (COLS + 1) + c] = swap_half(cval[r * COLS + c][SIDE_W]);
                end
                if (cwr[r * COLS + c][SIDE_E]) begin
                    if (c == COLS - 1 && cval[r * COLS + c][SIDE_E] != MEM_EMPTY) en_e_d[r] = 1'b1;
                    else vmem_d[r * (COLS + 1) + c + 1] = cval[r * COLS + c][SIDE_E];
                end
            end
        end
        if (inj_valid_i && inj_ok) begin
            case (inj_side_i)
                SIDE_N: if (hmem_q[32'(inj_idx_i)] == MEM_EMPTY) begin
                    hmem_d[32'(inj_idx_i)] = PHYS_INC;
                    inj_do = 1'b1;
                end
                SIDE_S: if (hmem_q[ROWS * COLS + 32'(inj_idx_i)] == MEM_EMPTY) begin
                    hmem_d[ROWS * COLS + 32'(inj_idx_i)] = PHYS_DEC;
                    inj_do = 1'b1;
                end
                SIDE_W: if (vmem_q[32'(inj_idx_i) * (COLS + 1)] == MEM_EMPTY) begin
                    vmem_d[32'(inj_idx_i) * (COLS + 1)] = PHYS_INC;
                    inj_do = 1'b1;
                end
                default: if (vmem_q[32'(inj_idx_i) * (COLS + 1) + COLS] == MEM_EMPTY) begin
                    vmem_d[32'(inj_idx_i) * (COLS + 1) + COLS] = PHYS_DEC;
                    inj_do = 1'b1;
                end
            endcase
        end
    end

    // Edge state and emit pulse registers; markers are loaded at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NH; i++) hmem_q[i] <= MARK_H[i] ? MEM_MARK : MEM_EMPTY;
            for (int i = 0; i < NV; i++) vmem_q[i] <= MARK_V[i] ? MEM_MARK : MEM_EMPTY;
            emit_n_o <= '0;
            emit_s_o <= '0;
            emit_w_o <= '0;
            emit_e_o <= '0;
        end else begin
            hmem_q   <= hmem_d;
            vmem_q   <= vmem_d;
            emit_n_o <= en_n_d;
            emit_s_o <= en_s_d;
            emit_w_o <= en_w_d;
            emit_e_o <= en_e_d;
        end
    end

    assign hmem_o = hmem_q;
    assign vmem_o = vmem_q;

    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|fire) && !inj_do) |=> ($stable(hmem_q) && $stable(vmem_q))); // R9
    AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{emit_n_o, emit_s_o, emit_w_o, emit_e_o}) |-> $past(|fire)); // R8
    AST_EMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|emit_n_o) |=> !(|(emit_n_o & $past(emit_n_o)))); // R8

    for (genvar i = 0; i < NV; i++) begin : g_vmark
        AST_VMARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (vmem_q[i] == MEM_MARK) |=> (vmem_q[i] == MEM_MARK)); // R4
    end
    for (genvar i = 0; i < NH; i++) begin : g_hmark
        AST_HMARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (hmem_q[i] == MEM_MARK) |=> (hmem_q[i] == MEM_MARK)); // R4
    end
endmodule

// File: tb/test_aca_grid.sv
// Scoreboard bench: tasks queue expected emit codes, a monitor consumes them.
// Emit code = side*8 + index, with side 0=N,1=E,2=S,3=W.
module test_aca_grid;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int NH   = (ROWS + 1) * COLS;
    localparam int NV   = ROWS * (COLS + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 inj_valid = 1'b0;
    logic [1:0]           inj_side = '0;
    logic [2:0]           inj_idx = '0;
    logic [2*NH-1:0]      hmem;
    logic [2*NV-1:0]      vmem;
    logic [COLS-1:0]      emit_n, emit_s;
    logic [ROWS-1:0]      emit_w, emit_e;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [2*NH-1:0] exp_h;
    logic [2*NV-1:0] exp_v;

    always #5 clk = ~clk;

    aca_grid i_aca_grid (
        .clk         (clk),
        .rst_n       (rst_n),
        .inj_valid_i (inj_valid),
        .inj_side_i  (inj_side),
        .inj_idx_i   (inj_idx),
        .hmem_o      (hmem),
        .vmem_o      (vmem),
        .emit_n_o    (emit_n),
        .emit_s_o    (emit_s),
        .emit_w_o    (emit_w),
        .emit_e_o    (emit_e)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor side: consume one expected emit per observed pulse.
    task automatic take(input int code);
        int pos = -1;
        for (int j = 0; j < exp_q.size(); j++) if (pos < 0 && exp_q[j] == code) pos = j;
        checks++;
        if (pos < 0) begin
            errors++;
            $display("FAIL R8 unexpected emit actual=%0d expected=none", code);
        end else begin
            exp_q.delete(pos);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < COLS; i++) if (emit_n[i]) take(0 * 8 + i);
            for (int i = 0; i < ROWS; i++) if (emit_e[i]) take(1 * 8 + i);
            for (int i = 0; i < COLS; i++) if (emit_s[i]) take(2 * 8 + i);
            for (int i = 0; i < ROWS; i++) if (emit_w[i]) take(3 * 8 + i);
        end
    end

    task automatic reset_grid();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_h = '0;
        exp_v = '0;
        exp_v[2*7 +: 2] = 2'b11;
    endtask

    task automatic inject(input int side, input int idx);
        @(negedge clk);
        inj_valid = 1'b1;
        inj_side  = 2'(side);
        inj_idx   = 3'(idx);
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic expect_emit(input int code);
        exp_q.push_back(code);
    endtask

    // Let activity die out, then compare queue and full edge state.
    task automatic settle(input string req);
        repeat (2000) @(negedge clk);
        check(exp_q.size() == 0, req, "missing emits", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        check(hmem == exp_h, req, "hmem state", 64'(hmem), 64'(exp_h));
        check(vmem == exp_v, req, "vmem state", 64'(vmem), 64'(exp_v));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        reset_grid();
        check(hmem == exp_h, "R1", "reset hmem", 64'(hmem), 64'(exp_h));
        check(vmem == exp_v, "R1", "reset vmem", 64'(vmem), 64'(exp_v));
        check({emit_n, emit_s, emit_w, emit_e} == '0, "R1", "reset emits",
              64'({emit_n, emit_s, emit_w, emit_e}), 64'd0);

        // R4 split from the west; R6 R7 injected value visible next cycle
        inject(3, 1);
        check(vmem[2*5 +: 2] == 2'b01, "R6", "west inject value", 64'(vmem[2*5 +: 2]), 64'd1);
        expect_emit(0 * 8 + 1);
        expect_emit(2 * 8 + 1);
        settle("R4");

        // R4 split rotated: arrives from the east at the other side of the marker
        reset_grid();
        inject(1, 1);
        check(vmem[2*9 +: 2] == 2'b10, "R7", "east inject value", 64'(vmem[2*9 +: 2]), 64'd2);
        expect_emit(0 * 8 + 2);
        expect_emit(2 * 8 + 2);
        settle("R4");

        // R3 straight travel eastward, westward, southward, northward
        reset_grid();
        inject(3, 0);
        expect_emit(1 * 8 + 0);
        settle("R3");
        inject(1, 3);
        expect_emit(3 * 8 + 3);
        settle("R3");
        inject(0, 0);
        check(hmem[2*0 +: 2] == 2'b01, "R6", "north inject value", 64'(hmem[2*0 +: 2]), 64'd1);
        expect_emit(2 * 8 + 0);
        settle("R3");
        inject(2, 3);
        check(hmem[2*19 +: 2] == 2'b10, "R6", "south inject value", 64'(hmem[2*19 +: 2]), 64'd2);
        expect_emit(0 * 8 + 3);
        settle("R8");

        // R5 signal reaching the marker cell from its side stays put
        reset_grid();
        inject(0, 1);
        exp_h[2*5 +: 2] = 2'b01;
        settle("R5");

        // R7 out-of-range index ignored; R9 state holds afterwards
        reset_grid();
        inject(3, 5);
        check(vmem == exp_v && hmem == exp_h, "R7", "out of range inject",
              64'(vmem), 64'(exp_v));
        settle("R9");

        // R2 repeated traversals through the schedule on one row
        reset_grid();
        for (int n = 0; n < 3; n++) begin
            inject(3, 2);
            expect_emit(1 * 8 + 2);
            settle("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule